// File: doc/BRIEF.md
# Serial EEPROM Sequential Byte Reader

This block fetches a run of consecutive bytes from a small serial EEPROM that has an SPI-style four-wire interface. A typical use is loading a factory-programmed station address at boot. The controller supplies a starting byte address and a byte count, then pulses `start`. The block drives chip select, serial clock and serial data toward the memory, and it samples the memory's serial data output. Each byte it recovers is presented on `data`, qualified by a one-cycle `byte_valid` strobe.

Every byte is fetched by its own framed transaction. Chip select goes low, the read command and then the address are shifted out, eight data bits are shifted in, and chip select goes high again. The address then advances by one and the next transaction starts. A single wake-up preamble of two serial clock pulses, sent with chip select inactive, comes before the first transaction of each request. Every half-period of the serial clock lasts `DIV` system clock cycles. An idle gap of the same length separates consecutive transactions. A one-cycle `done` pulse ends each request.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset and whenever `busy` is low, `cs_n` is high and `sck` is low.
- R2: For a request with a nonzero count, exactly two rising edges of `sck` occur while `cs_n` is high, and both come before the first transaction.
- R3: Each transaction first shifts out the command byte 0x03 on `mosi`, most significant bit first. The memory captures each bit on a rising edge of `sck`.
- R4: The eight bits after the command are the byte address, most significant bit first. The first transaction uses `start_addr`, and each later one uses the previous address plus one, wrapping from 0xFF to 0x00.
- R5: After the address, eight bits are sampled from `miso` during the low phase of `sck`, most significant bit first. They appear on `data` with a one-cycle `byte_valid` pulse, one per byte, in address order.
- R6: `mosi` never changes while `sck` is high.
- R7: Every high phase of `sck` lasts exactly `DIV` clock cycles. Between consecutive transactions of one request, `cs_n` is high for exactly `DIV` cycles.
- R8: `cs_n` is low only while `busy` is high. Each low period of `cs_n` contains exactly 24 rising edges of `sck`. A request with count N produces exactly N such periods.
- R9: `done` is a single-cycle pulse after the last byte of a request. `busy` is already low in the cycle where `done` is high.
- R10: A `start` with `count` equal to zero gives `done` in the following cycle. In that case `busy` stays low, no preamble runs and `cs_n` never goes low.
- R11: A `start` pulse while `busy` is high is ignored. It changes neither the bytes, the addresses nor the number of transactions, and no extra request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| start_addr | input | 8 | First byte address to read |
| count | input | 8 | Number of bytes to read |
| busy | output | 1 | Request in progress |
| byte_valid | output | 1 | One-cycle strobe qualifying `data` |
| data | output | 8 | Most recently read byte |
| done | output | 1 | One-cycle end-of-request pulse |
| cs_n | output | 1 | Memory chip select, active low |
| sck | output | 1 | Serial clock to the memory |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
The bench includes a behavioural memory model. The model decodes the command and address at each rising edge of the serial clock. It returns the contents of a computed byte pattern, so every byte differs from its neighbours and from its own address. The bench runs requests of several lengths from several start addresses. A run that starts near 0xFF separates correct 8-bit wrap-around from address carry errors. A single-byte run separates per-request setup from per-byte setup. A zero-count request checks that the preamble and chip select stay untouched. A request with a stray `start` pulse in the middle shows whether a busy request can be restarted or its address corrupted.

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_addr,
  input  logic [7:0] count,
  output logic       busy,
  output logic       byte_valid,
  output logic [7:0] data,
  output logic       done,
  output logic       cs_n,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW = 6;
  localparam int XFER_PHASES = 48;
  localparam int PRE_PHASES = 4;
  localparam logic [7:0] RD_CMD = 8'h03;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_XFER, S_GAP} state_t;

  state_t          st;
  logic [TW-1:0]   tcnt;
  logic [PW-1:0]   ph;
  logic [7:0]      addr;
  logic [7:0]      left;
  logic [7:0]      rx;
  logic [15:0]     sr;

  wire       tick = (tcnt == TW'(DIV - 1));
  wire [4:0] bitn = ph[5:1];

  assign busy = (st != S_IDLE);
  assign cs_n = (st != S_XFER);
  assign sck  = (st == S_PRE) ? ~ph[0] : (st == S_XFER) ? ph[0] : 1'b0;
  assign mosi = (st == S_XFER) & sr[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tcnt       <= '0;
      ph         <= '0;
      addr       <= '0;
      left       <= '0;
      rx         <= '0;
      sr         <= '0;
      data       <= '0;
      byte_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      done       <= 1'b0;
      if (st == S_IDLE) tcnt <= '0;
      else              tcnt <= tick ? '0 : tcnt + 1'b1;

      case (st)
        S_IDLE: begin
          if (start) begin
            if (count == 8'd0) begin
              done <= 1'b1;
            end else begin
              st   <= S_PRE;
              ph   <= '0;
              addr <= start_addr;
              left <= count;
            end
          end
        end
        S_PRE: begin
          if (tick) begin
            if (ph == PW'(PRE_PHASES - 1)) begin
              st <= S_XFER;
              ph <= '0;
              sr <= {RD_CMD, addr};
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        S_XFER: begin
          if (tick) begin
            if (!ph[0] && bitn >= 5'd16) rx <= {rx[6:0], miso};
            if (ph[0]) sr <= {sr[14:0], 1'b0};
            if (ph == PW'(XFER_PHASES - 1)) begin
              st         <= S_GAP;
              data       <= rx;
              byte_valid <= 1'b1;
              left       <= left - 1'b1;
              addr       <= addr + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (tick) begin
            ph <= '0;
            if (left == 8'd0) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_XFER;
              sr <= {RD_CMD, addr};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk #(
  parameter int DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] count,
  input logic       busy,
  input logic       byte_valid,
  input logic       done,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi
);
  logic        prev_sck;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      run      <= '0;
    end else begin
      prev_sck <= sck;
      if (sck != prev_sck)  run <= 16'd1;
      else if (run != '1)   run <= run + 1'b1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck)); // R1
  AST_MOSI_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck); // R6
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sck && !sck) |-> (run == 16'(DIV))); // R7
  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R5
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == 8'd0) |=> (done && !busy)); // R10
endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .count(count), .busy(busy),
  .byte_valid(byte_valid), .done(done), .cs_n(cs_n), .sck(sck), .mosi(mosi)
);

// File: tb/eeprom_seq_reader_tb.sv
module eeprom_seq_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [7:0] start_addr = 8'd0, count = 8'd0;
  logic busy, byte_valid, done, cs_n, sck, mosi;
  logic [7:0] data;

  int vectors = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_seq_reader #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .count(count),
    .busy(busy), .byte_valid(byte_valid), .data(data), .done(done),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] rom(input logic [7:0] a);
    return (a * 8'd37) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model
  int bitn = 0, pre_edges = 0, txn_cnt = 0;
  logic [15:0] cmd = '0;
  logic [7:0]  tx = '0, exp_addr = '0;

  always @(negedge cs_n) begin
    bitn = 0;
    txn_cnt++;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (bitn < 16) cmd = {cmd[14:0], mosi};
      bitn++;
      if (bitn == 16) begin
        chk(cmd[15:8] == 8'h03, "R3", "command byte", cmd[15:8], 8'h03);
        chk(cmd[7:0] == exp_addr, "R4", "address byte", cmd[7:0], exp_addr);
        exp_addr = exp_addr + 8'd1;
        tx = rom(cmd[7:0]);
      end
    end else begin
      pre_edges++;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && bitn >= 16 && bitn < 24) begin
      miso = tx[7];
      tx = {tx[6:0], 1'b0};
    end
  end

  always @(posedge cs_n) begin
    if (rst_n === 1'b1 && txn_cnt > 0)
      chk(bitn == 24, "R8", "rising edges in transaction", bitn, 24);
  end

  // scoreboard monitor and line timing
  logic prev_mosi = 1'b0, prev_sck = 1'b0, prev_cs = 1'b1;
  int hi_len = 0, cs_hi_len = 0;
  bit cs_seen_low = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected byte", data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R5", "read byte", data, e);
        end
      end
      if (mosi != prev_mosi && sck && prev_sck)
        chk(1'b0, "R6", "mosi moved in high phase", mosi, prev_mosi);
      if (prev_sck && !sck) chk(hi_len == DIV, "R7", "sck high length", hi_len, DIV);
      hi_len = sck ? hi_len + 1 : 0;
      if (prev_cs && !cs_n && txn_cnt > 1)
        chk(cs_hi_len == DIV, "R7", "gap between transactions", cs_hi_len, DIV);
      cs_hi_len = cs_n ? cs_hi_len + 1 : 0;
      if (!cs_n) cs_seen_low = 1'b1;
    end
    prev_mosi = mosi;
    prev_sck  = sck;
    prev_cs   = cs_n;
  end

  task automatic run_req(input logic [7:0] a, input int n, input bit poke);
    pre_edges = 0;
    txn_cnt = 0;
    cs_seen_low = 1'b0;
    exp_addr = a;
    for (int i = 0; i < n; i++) exp_q.push_back(rom(a + 8'(i)));
    @(negedge clk);
    start_addr = a;
    count = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R10", "done after zero count", done, 1);
      chk(busy == 1'b0, "R10", "busy on zero count", busy, 0);
      repeat (60) @(negedge clk);
      chk(!cs_seen_low, "R10", "cs_n asserted on zero count", cs_seen_low, 0);
      chk(pre_edges == 0, "R10", "preamble on zero count", pre_edges, 0);
    end else begin
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      if (poke) begin
        repeat (200) @(negedge clk);
        start_addr = ~a;
        count = 8'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      begin
        int t;
        t = 0;
        while (!done && t < 20000) begin
          @(negedge clk);
          t++;
        end
      end
      chk(done == 1'b1, "R9", "done pulse seen", done, 1);
      chk(busy == 1'b0, "R9", "busy while done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done width", done, 0);
      chk(exp_q.size() == 0, "R5", "bytes outstanding", exp_q.size(), 0);
      chk(pre_edges == 2, "R2", "preamble edges", pre_edges, 2);
      chk(txn_cnt == n, "R8", "transaction count", txn_cnt, n);
      if (poke) begin
        repeat (300) @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after ignored start", busy, 0);
        chk(txn_cnt == n, "R11", "transactions after ignored start", txn_cnt, n);
      end
      chk(cs_n == 1'b1 && sck == 1'b0, "R1", "idle pins", {cs_n, sck}, 2'b10);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1", "pins in reset", {cs_n, sck}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && byte_valid == 1'b0, "R1", "reset outputs",
        {busy, done, byte_valid}, 0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1", "pins after reset", {cs_n, sck}, 2'b10);
    run_req(8'h10, 3, 1'b0);
    run_req(8'hFE, 4, 1'b0);
    run_req(8'h00, 0, 1'b0);
    run_req(8'h7F, 1, 1'b0);
    run_req(8'h3A, 5, 1'b1);
    run_req(8'hC5, 2, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule